// File: doc/BRIEF.md
# Word-Wide String Length Scanner

This block measures a zero-terminated byte string held in memory. Software or a neighbouring engine hands it a byte start address and a one-cycle start strobe. The block then walks memory one aligned 32-bit word at a time through a simple read port with one outstanding request. When it finds the terminating zero byte, it returns the number of bytes that precede that zero and raises a one-cycle done pulse.

Each fetched word is tested in all four byte lanes at once, so a long string costs one read per four characters rather than one per character. The first fetch is always aligned. When the start address is not word aligned, the lanes in front of the start are forced non-zero. The running count is also seeded with minus the start offset, so that those lanes cancel out of the final length. Memory is little-endian: the byte at address `a` sits in lane `a[1:0]`, and lane 0 is bits 7:0 of the read data.

Top module: `strscan_top`

## Requirements
- R1: The first read after a start is issued at the start address with its two low bits cleared; `rd_addr_o[1:0]` is always 0 while `rd_req_o` is high.
- R2: When the start is unaligned, the lanes of the first word below the start offset never end the scan, even when they hold zero bytes.
- R3: `len_o` equals the number of non-zero bytes from the start address up to the first zero byte at or after it. Lanes are examined from lane 0 (bits 7:0) upward, and the byte at address `a` is in lane `a[1:0]`.
- R4: A zero byte exactly at the start address yields length 0, for aligned and unaligned starts alike.
- R5: A word with no zero in any examined lane makes the scan continue with a read at the previous address plus 4. A scan that ends at byte address `e` issues exactly `e/4 - start/4 + 1` reads.
- R6: Only one read is outstanding. `rd_req_o` is high for single cycles, and no new request is raised until `rd_valid_i` has returned the data of the previous one. `rd_valid_i` is accepted only while a read is outstanding.
- R7: `done_o` is a one-cycle pulse, and `len_o` changes only in the cycle where `done_o` is high. It then holds its value until the next result.
- R8: A start strobe that arrives while a scan is in progress is ignored. The running scan finishes with its own result, and no second scan follows.
- R9: While reset is asserted, `done_o`, `rd_req_o` and `len_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| start_i | input | 1 | Start strobe, sampled only when idle |
| start_addr_i | input | 32 | Byte address of the first character |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | 32 | Word-aligned read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Read data, little-endian byte lanes |
| done_o | output | 1 | One-cycle result pulse |
| len_o | output | 32 | String length in bytes |

## Verification
The hardest case to reach from the ports is a zero byte sitting in the first word in front of an unaligned start. It only matters when the lane mask and the negative count seed both act on the same word. The memory model places zero bytes at addresses 5 and 6, and the stimulus starts scans at addresses 2 and 7: the first must stop at the zero at 5, and the second must skip both zeros and run on into the next words. A second awkward case is a start strobe landing mid-scan. The bench fires one while a read is outstanding and then watches the ports long enough to prove that no extra read or result appears. The memory model also varies its read latency from vector to vector, so that acceptance of the valid strobe is exercised at several distances from the request.

// File: rtl/strscan_pkg.sv
package strscan_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } scan_state_e;
endpackage

// File: rtl/strscan_rst_sync.sv
module strscan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/strscan_lane_zero.sv
module strscan_lane_zero #(
  parameter int LANES = 4,
  parameter int BW    = 8,
  localparam int OW   = $clog2(LANES),
  localparam int DW   = LANES * BW
) (
  input  logic [DW-1:0]    word_i,
  input  logic             first_i,
  input  logic [OW-1:0]    off_i,
  output logic [LANES-1:0] zero_o
);
  // Lanes below the start offset in the first word are treated as non-zero.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic hidden;
    assign hidden    = first_i && (l < int'(off_i));
    assign zero_o[l] = !hidden && (word_i[l*BW +: BW] == '0);
  end
endmodule

// File: rtl/strscan_first_zero.sv
module strscan_first_zero #(
  parameter int LANES = 4,
  localparam int OW   = $clog2(LANES)
) (
  input  logic [LANES-1:0] zero_i,
  output logic             found_o,
  output logic [OW-1:0]    lead_o
);
  // Number of lanes in front of the lowest zero lane.
  always_comb begin
    found_o = |zero_i;
    lead_o  = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (zero_i[l]) begin
        lead_o = OW'(l);
      end
    end
  end
endmodule

// File: rtl/strscan_ctrl.sv
module strscan_ctrl
  import strscan_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 32,
  parameter int LANES = 4,
  localparam int OW   = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          rd_valid_i,
  input  logic          found_i,
  input  logic [OW-1:0] lead_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          first_o,
  output logic [OW-1:0] off_o,
  output logic          done_o,
  output logic [LW-1:0] len_o
);
  scan_state_e   state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] len_q, len_d;
  logic [OW-1:0] off_q, off_d;
  logic          first_q, first_d;
  logic          done_q, done_d;
  logic          addr_en, cnt_en, len_en;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    off_d   = off_q;
    first_d = first_q;
    done_d  = 1'b0;
    addr_en = 1'b0;
    cnt_en  = 1'b0;
    len_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          addr_d  = {start_addr_i[AW-1:OW], {OW{1'b0}}};
          off_d   = start_addr_i[OW-1:0];
          cnt_d   = LW'(0) - LW'(start_addr_i[OW-1:0]);
          first_d = 1'b1;
          addr_en = 1'b1;
          cnt_en  = 1'b1;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rd_valid_i) begin
          if (found_i) begin
            len_d   = cnt_q + LW'(lead_i);
            len_en  = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            cnt_d   = cnt_q + LW'(LANES);
            addr_d  = addr_q + AW'(LANES);
            first_d = 1'b0;
            addr_en = 1'b1;
            cnt_en  = 1'b1;
            state_d = ST_FETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      off_q   <= '0;
      first_q <= 1'b0;
    end else if (addr_en) begin
      addr_q  <= addr_d;
      off_q   <= off_d;
      first_q <= first_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_en) begin
      len_q <= len_d;
    end
  end

  assign rd_req_o  = (state_q == ST_FETCH);
  assign rd_addr_o = addr_q;
  assign first_o   = first_q;
  assign off_o     = off_q;
  assign done_o    = done_q;
  assign len_o     = len_q;
endmodule

// File: rtl/strscan_top.sv
module strscan_top
  import strscan_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 32,
  parameter int LANES = 4,
  localparam int OW   = $clog2(LANES),
  localparam int DW   = LANES * BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          done_o,
  output logic [LW-1:0] len_o
);
  logic             rst_int_n;
  logic             first_w;
  logic [OW-1:0]    off_w;
  logic [LANES-1:0] zero_w;
  logic             found_w;
  logic [OW-1:0]    lead_w;

  strscan_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  strscan_lane_zero #(.LANES(LANES), .BW(BYTE_W)) u_lane (
    .word_i  (rd_data_i),
    .first_i (first_w),
    .off_i   (off_w),
    .zero_o  (zero_w)
  );

  strscan_first_zero #(.LANES(LANES)) u_prio (
    .zero_i  (zero_w),
    .found_o (found_w),
    .lead_o  (lead_w)
  );

  strscan_ctrl #(.AW(AW), .LW(LW), .LANES(LANES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .rd_valid_i   (rd_valid_i),
    .found_i      (found_w),
    .lead_i       (lead_w),
    .rd_req_o     (rd_req_o),
    .rd_addr_o    (rd_addr_o),
    .first_o      (first_w),
    .off_o        (off_w),
    .done_o       (done_o),
    .len_o        (len_o)
  );
endmodule

// File: rtl/strscan_chk.sv
module strscan_chk #(
  parameter int AW = 32,
  parameter int LW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_valid_i,
  input logic          done_o,
  input logic [LW-1:0] len_o
);
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (rd_addr_o[1:0] == 2'b00)); // R1

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o); // R6

  AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_req_o); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(len_o)); // R7

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!done_o && !rd_req_o); // R9
    end
  end
endmodule

bind strscan_top strscan_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .rd_valid_i (rd_valid_i),
  .done_o     (done_o),
  .len_o      (len_o)
);

// File: tb/sim_strscan_top.sv
module sim_strscan_top;
  localparam int MEM_BYTES = 128;
  localparam int NVEC      = 15;
  // {start address, expected length}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'd0,  16'd5},  {16'd1,  16'd4},  {16'd2,  16'd3},
    {16'd3,  16'd2},  {16'd4,  16'd1},  {16'd5,  16'd0},
    {16'd6,  16'd0},  {16'd7,  16'd12}, {16'd8,  16'd11},
    {16'd20, 16'd20}, {16'd21, 16'd19}, {16'd41, 16'd36},
    {16'd43, 16'd34}, {16'd78, 16'd42}, {16'd100, 16'd20}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic        rd_req_o;
  logic [31:0] rd_addr_o;
  logic        rd_valid_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        done_o;
  logic [31:0] len_o;

  int n_chk = 0;
  int n_err = 0;
  int lat = 0;
  int pend = 0;
  int pcnt = 0;
  int nfetch = 0;
  logic [31:0] paddr = '0;
  logic [31:0] last_addr = '0;
  logic [31:0] first_addr = '0;
  int fetch_base = 0;

  always #2 clk = ~clk;

  strscan_top u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .rd_req_o     (rd_req_o),
    .rd_addr_o    (rd_addr_o),
    .rd_valid_i   (rd_valid_i),
    .rd_data_i    (rd_data_i),
    .done_o       (done_o),
    .len_o        (len_o)
  );

  function automatic logic [7:0] mem_byte(input int a);
    if (a == 5 || a == 6 || a == 19 || a == 40 || a == 77 || a == 120 || a >= MEM_BYTES)
      return 8'h00;
    return 8'h41 + 8'(a % 26);
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {mem_byte(int'(a) + 3), mem_byte(int'(a) + 2),
            mem_byte(int'(a) + 1), mem_byte(int'(a))};
  endfunction

  // Memory responder: answers each request after a variable number of cycles
  always @(negedge clk) begin
    rd_valid_i <= 1'b0;
    if (pend != 0) begin
      if (pcnt == 0) begin
        rd_valid_i <= 1'b1;
        rd_data_i  <= mem_word(paddr);
        pend       <= 0;
      end else begin
        pcnt <= pcnt - 1;
      end
    end
    if (rd_req_o) begin
      pend      <= 1;
      pcnt      <= lat;
      paddr     <= rd_addr_o;
      last_addr <= rd_addr_o;
      nfetch    <= nfetch + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [31:0] a);
    @(negedge clk);
    start_addr_i = a;
    start_i      = 1'b1;
    @(negedge clk);
    start_i      = 1'b0;
  endtask

  task automatic wait_done(output int ok);
    ok = 0;
    for (int c = 0; c < 500; c++) begin
      if (done_o) begin
        ok = 1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input int a, input int exp);
    int ok;
    int exp_fetch;
    logic [31:0] held;
    fetch_base = nfetch;
    pulse_start(32'(a));
    // capture the first fetch address as soon as it appears
    for (int c = 0; c < 20; c++) begin
      if (nfetch != fetch_base) break;
      @(negedge clk);
    end
    first_addr = last_addr;
    check("R1 first fetch address", int'(first_addr), a & ~3);
    wait_done(ok);
    check("R7 done seen", ok, 1);
    check("R3 length", int'(len_o), exp);
    if (exp == 0) check("R4 zero at start", int'(len_o), 0);
    if ((a & 3) != 0) check("R2 unaligned start", int'(len_o), exp);
    exp_fetch = ((a + exp) >> 2) - (a >> 2) + 1;
    check("R5 fetch count", nfetch - fetch_base, exp_fetch);
    held = len_o;
    @(negedge clk);
    check("R7 done single cycle", int'(done_o), 0);
    check("R7 length held", int'(len_o), int'(held));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired (all requirements) actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int ok;
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 done in reset", int'(done_o), 0);
    check("R9 req in reset", int'(rd_req_o), 0);
    check("R9 len in reset", int'(len_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      lat = i % 3;
      run_vec(int'(VEC[i][31:16]), int'(VEC[i][15:0]));
    end

    // R8: start while busy is ignored
    lat = 2;
    fetch_base = nfetch;
    pulse_start(32'd78);
    repeat (3) @(negedge clk);
    start_addr_i = 32'd0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(ok);
    check("R8 busy scan completes", ok, 1);
    check("R8 result of first scan", int'(len_o), 42);
    fetch_base = nfetch;
    ok = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (done_o || rd_req_o) ok = 1;
    end
    check("R8 no second scan", ok, 0);
    check("R6 no extra fetch", nfetch - fetch_base, 0);

    // R9: reset in the middle of a scan
    lat = 3;
    pulse_start(32'd100);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 len cleared by reset", int'(len_o), 0);
    check("R9 done cleared by reset", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    lat = 0;
    run_vec(1, 4);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule